// File: doc/BRIEF.md
# Synchronous Burst SRAM with Address Sequencer

A single-clock static RAM of 32-bit words, meant to sit next to a processor cache. At each rising clock edge it samples its address, write data, three chip enables, two address strobes (one for the processor and one for the cache controller), an advance input, and its write enables. It then performs one access, either a read or a byte-masked write.

A strobe loads a new burst start address. A 2-bit sequencer then supplies the other three word addresses of a four-beat burst, stepping only in cycles where advance is asserted. The step order is linear or interleaved, selected by a pin. The output enable acts without the clock and only gates whether read data is driven.

Depth is set by the address-width parameter. The data paths are plain pins rather than valid/ready streams, because an SRAM access cannot be stalled: each selected cycle is exactly one access.

Top module: `sbsr_burst_ram`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dq_oe` is low and `rd_data` is zero.
- R2: A cycle with `adsp_n` or `adsc_n` low (active low) loads `addr` as the burst start. If the device is selected and the cycle is a read, the word at `addr` appears on `rd_data` with `dq_oe` high right after that edge.
- R3: The device is selected only if `ce1_n`=0, `ce2`=1 and `ce3_n`=0 at the loading edge. While deselected, nothing is written, and `dq_oe` stays low until a later load selects it.
- R4: With `mode`=0 (linear), the low two address bits of beat k are (start + k) mod 4.
- R5: With `mode`=1 (interleaved), the low two address bits of beat k are start XOR k.
- R6: In a cycle without a strobe, `adv_n`=0 steps the beat count by one, wrapping after beat 3, and `adv_n`=1 repeats the current address. The upper address bits never change inside a burst.
- R7: `gw_n`=0 writes all four bytes of `wr_data`.
- R8: With `gw_n`=1 and `bwe_n`=0, byte lane i (`wr_data[8i+7:8i]`) is written only where `bw_n[i]`=0. If `gw_n`=1 and `bwe_n`=1, the cycle is a read.
- R9: A cycle with `adsp_n`=0 is always a read. All write enables are ignored in that cycle.
- R10: A cycle that loads through `adsc_n` alone, and every non-strobe cycle, may write.
- R11: `dq_oe` = NOT `oe_n` AND (the last access was a selected read), with no clock involved. `rd_data` is zero whenever `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of sequencer and output state |
| addr | input | ADDR_W | Word address, sampled on a strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, zero when not driven |
| dq_oe | output | 1 | High when read data is driven |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write master enable, active low |
| bw_n | input | 4 | Byte lane enables, active low |
| mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Output enable, active low, asynchronous |

## Verification
A corrupted beat counter or start register shows up in the very next read beat as a word taken from the wrong address. Every word in the test window therefore holds a distinct value, so such an error surfaces within one clock. A wrong select flag shows up at once on `dq_oe`. A mis-decoded write mask stays hidden until that word is read again, so each write burst in the bench is followed by reads of the same words, both directed and random.

// File: rtl/sbsr_pkg.sv
package sbsr_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_ord_e;

  localparam int BEAT_W = 2;

  // Low address bits for beat k of a burst that began at start.
  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input burst_ord_e        ord
  );
    if (ord == ORD_INTERLEAVE) return start ^ beat;
    return start + beat;
  endfunction
endpackage

// File: rtl/sbsr_addr_gen.sv
module sbsr_addr_gen
  import sbsr_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          mode,
  input  logic          ce_ok,
  input  logic [AW-1:0] addr,
  output logic          ld,
  output logic          acc_sel,
  output logic [AW-1:0] acc_addr
);
  localparam int HI_W = AW - BEAT_W;

  logic [HI_W-1:0]   base_q;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] cnt_q;
  logic [BEAT_W-1:0] cnt_nxt;
  logic              sel_q;
  burst_ord_e        ord;

  assign ord = burst_ord_e'(mode);
  assign ld  = !adsp_n || !adsc_n;

  always_comb begin
    if (ld)          cnt_nxt = '0;
    else if (!adv_n) cnt_nxt = cnt_q + 1'b1;
    else             cnt_nxt = cnt_q;
  end

  assign acc_addr = ld ? addr : {base_q, beat_offset(start_q, cnt_nxt, ord)};
  assign acc_sel  = ld ? ce_ok : sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (ld) begin
        base_q  <= addr[AW-1:BEAT_W];
        start_q <= addr[BEAT_W-1:0];
        sel_q   <= ce_ok;
      end
    end
  end

  // Record of the previous access address, kept for the checks below.
  logic [AW-1:0] last_acc_q;
  always_ff @(posedge clk) begin
    if (!rst_n) last_acc_q <= '0;
    else        last_acc_q <= acc_addr;
  end

  // R6
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && adv_n) |-> (acc_addr == last_acc_q));
  // R6
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |-> (acc_addr[AW-1:BEAT_W] == last_acc_q[AW-1:BEAT_W]));
  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv_n && !mode && !$past(mode))
      |-> (acc_addr[BEAT_W-1:0] == last_acc_q[BEAT_W-1:0] + 1'b1));
  // R5
  ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv_n && mode && $past(mode))
      |-> ((acc_addr[BEAT_W-1:0] ^ start_q) ==
           ((last_acc_q[BEAT_W-1:0] ^ start_q) + 1'b1)));
endmodule

// File: rtl/sbsr_wr_ctl.sv
module sbsr_wr_ctl #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adsp_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bw_n,
  output logic [NB-1:0] wr_mask
);
  always_comb begin
    if (!adsp_n)     wr_mask = '0;
    else if (!gw_n)  wr_mask = '1;
    else if (!bwe_n) wr_mask = ~bw_n;
    else             wr_mask = '0;
  end

  // R9
  proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adsp_n |-> (wr_mask == '0));
  // R7
  global_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adsp_n && !gw_n) |-> (&wr_mask));
  // R8
  no_enable_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && bwe_n) |-> (wr_mask == '0));
endmodule

// File: rtl/sbsr_lane.sv
module sbsr_lane #(
  parameter int AW = 10,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] wdata,
  output logic [LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/sbsr_burst_ram.sv
module sbsr_burst_ram #(
  parameter int ADDR_W = 10,
  parameter int BYTES  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [8*BYTES-1:0]   wr_data,
  output logic [8*BYTES-1:0]   rd_data,
  output logic                 dq_oe,
  input  logic                 ce1_n,
  input  logic                 ce2,
  input  logic                 ce3_n,
  input  logic                 adsp_n,
  input  logic                 adsc_n,
  input  logic                 adv_n,
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [BYTES-1:0]     bw_n,
  input  logic                 mode,
  input  logic                 oe_n
);
  localparam int LW = 8;
  localparam int DW = LW * BYTES;

  logic              ld;
  logic              ce_ok;
  logic              acc_sel;
  logic [ADDR_W-1:0] acc_addr;
  logic [BYTES-1:0]  wr_mask;
  logic              rd_en;
  logic              rd_vld_q;
  logic [DW-1:0]     lane_q;

  assign ce_ok = !ce1_n && ce2 && !ce3_n;

  sbsr_addr_gen #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .mode(mode), .ce_ok(ce_ok), .addr(addr),
    .ld(ld), .acc_sel(acc_sel), .acc_addr(acc_addr)
  );

  sbsr_wr_ctl #(.NB(BYTES)) u_wr (
    .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .wr_mask(wr_mask)
  );

  assign rd_en = acc_sel && (wr_mask == '0);

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    sbsr_lane #(.AW(ADDR_W), .LW(LW)) u_lane (
      .clk(clk),
      .we(acc_sel && wr_mask[g]),
      .re(rd_en),
      .addr(acc_addr),
      .wdata(wr_data[g*LW +: LW]),
      .rdata(lane_q[g*LW +: LW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_vld_q <= 1'b0;
    else        rd_vld_q <= rd_en;
  end

  assign dq_oe   = !oe_n && rd_vld_q;
  assign rd_data = dq_oe ? lane_q : '0;

  // R3
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !ce_ok) |=> !dq_oe);
  // R2
  load_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && ce_ok) |=> rd_vld_q);
  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (rd_data == '0));
endmodule

// File: tb/sbsr_burst_ram_tb.sv
`timescale 1ns/1ps
module sbsr_burst_ram_tb;
  localparam int AW = 10;
  localparam logic [AW-1:0] WIN = 10'h1F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic dq_oe;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0] bw_n = 4'hF;
  logic mode = 1'b0, oe_n = 1'b0;

  always #10 clk = ~clk;

  sbsr_burst_ram #(.ADDR_W(AW), .BYTES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .dq_oe(dq_oe), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .mode(mode), .oe_n(oe_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model state
  logic [31:0] mref [1 << AW];
  logic [AW-3:0] m_base = '0;
  logic [1:0] m_st = '0, m_cnt = '0;
  logic m_sel = 1'b0;
  logic exp_vld = 1'b0;
  logic [31:0] exp_data = '0;

  function automatic logic [1:0] ofs(input logic [1:0] s, input logic [1:0] k, input logic ilv);
    return ilv ? (s ^ k) : (s + k);
  endfunction

  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    return 32'hC3A5_0000 | {22'd0, a} | ({22'd0, a} << 20);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [3:0] msk;
    logic [AW-1:0] a;
    if (!adsp_n || !adsc_n) begin
      m_base = addr[AW-1:2]; m_st = addr[1:0]; m_cnt = 2'd0;
      m_sel = !ce1_n && ce2 && !ce3_n;
    end else if (!adv_n) begin
      m_cnt = m_cnt + 2'd1;
    end
    a = {m_base, ofs(m_st, m_cnt, mode)};
    if (!adsp_n)     msk = 4'h0;
    else if (!gw_n)  msk = 4'hF;
    else if (!bwe_n) msk = ~bw_n;
    else             msk = 4'h0;
    if (!m_sel) exp_vld = 1'b0;
    else if (msk != 4'h0) begin
      for (int i = 0; i < 4; i++)
        if (msk[i]) mref[a][i*8 +: 8] = wr_data[i*8 +: 8];
      exp_vld = 1'b0;
    end else begin
      exp_vld = 1'b1;
      exp_data = mref[a];
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, {31'd0, dq_oe}, {31'd0, exp_vld && !oe_n});
    check(tag, rd_data, (exp_vld && !oe_n) ? exp_data : 32'd0);
  endtask

  task automatic idle_in();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF;
  endtask

  // R10 R7: controller-strobe burst that writes the fill pattern
  task automatic burst_fill(input logic [AW-1:0] a, input logic ilv);
    mode = ilv;
    for (int k = 0; k < 4; k++) begin
      idle_in();
      gw_n = 1'b0;
      if (k == 0) begin adsc_n = 1'b0; addr = a; end
      else adv_n = 1'b0;
      wr_data = pat({a[AW-1:2], ofs(a[1:0], k[1:0], ilv)});
      tick("R10");
    end
    idle_in();
  endtask

  // R4 R5 R9: read burst; a processor load also raises global write
  task automatic burst_read(input logic [AW-1:0] a, input logic ilv, input logic proc);
    mode = ilv;
    for (int k = 0; k < 4; k++) begin
      idle_in();
      if (k == 0) begin
        addr = a;
        if (proc) begin adsp_n = 1'b0; gw_n = 1'b0; wr_data = 32'hDEAD_BEEF; end
        else adsc_n = 1'b0;
      end else adv_n = 1'b0;
      tick(proc ? "R9" : (ilv ? "R5" : "R4"));
      if (!proc || k > 0) check(ilv ? "R5" : "R4", rd_data, pat({a[AW-1:2], ofs(a[1:0], k[1:0], ilv)}));
    end
    idle_in();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mref[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", {31'd0, dq_oe}, 32'd0);
    check("R1", rd_data, 32'd0);
    rst_n = 1'b1;
    tick("R1");

    // Fill window, alternating order
    for (int b = 0; b < 4; b++) burst_fill(WIN + AW'(b * 4), b[0]);

    // Bursts from every start offset, both orders, both strobes
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 2; o++) begin
        burst_read(WIN + AW'(4 + s), o[0], 1'b0);
        burst_read(WIN + AW'(8 + s), o[0], 1'b1);
      end

    // R6: wrap past beat 3 and hold with adv_n high
    mode = 1'b0; addr = WIN + 10'd2; adsp_n = 1'b0; tick("R6");
    idle_in(); tick("R6");
    check("R6", rd_data, pat(WIN + 10'd2));
    for (int k = 1; k <= 4; k++) begin adv_n = 1'b0; tick("R6"); end
    check("R6", rd_data, pat(WIN + 10'd2));
    idle_in(); tick("R6");

    // R3: deselected global write leaves data and output quiet
    ce2 = 1'b0; addr = WIN + 10'd5; adsc_n = 1'b0; gw_n = 1'b0; wr_data = 32'h0BAD_0BAD;
    tick("R3");
    adsc_n = 1'b1; ce2 = 1'b1; adv_n = 1'b0; tick("R3");
    idle_in();
    burst_read(WIN + 10'd5, 1'b0, 1'b0);

    // R8: byte lanes 0 and 2 only
    addr = WIN + 10'd9; adsc_n = 1'b0; bwe_n = 1'b0; bw_n = 4'b1010; wr_data = 32'h1122_3344;
    tick("R8");
    idle_in(); addr = WIN + 10'd9; adsc_n = 1'b0; tick("R8");
    check("R8", rd_data, {pat(WIN + 10'd9)[31:24], 8'h22, pat(WIN + 10'd9)[15:8], 8'h44});
    // R8: bwe_n high with lanes enabled is a read
    idle_in(); bw_n = 4'h0; wr_data = 32'hFFFF_FFFF; tick("R8");
    check("R8", rd_data, {pat(WIN + 10'd9)[31:24], 8'h22, pat(WIN + 10'd9)[15:8], 8'h44});

    // R11: asynchronous output enable
    idle_in(); oe_n = 1'b1; tick("R11");
    oe_n = 1'b0; #1;
    check("R11", {31'd0, dq_oe}, 32'd1);
    check("R11", rd_data, mref[WIN + 10'd9]);
    @(negedge clk);

    // Random phase
    void'($urandom(32'd4242));
    for (int c = 0; c < 600; c++) begin
      idle_in();
      adsp_n = ($urandom % 5) != 0;
      adsc_n = ($urandom % 4) != 0;
      adv_n  = ($urandom % 2) != 0;
      gw_n   = ($urandom % 6) != 0;
      bwe_n  = ($urandom % 3) != 0;
      bw_n   = 4'($urandom);
      ce2    = ($urandom % 8) != 0;
      oe_n   = ($urandom % 8) == 0;
      wr_data = $urandom;
      if (!adsp_n || !adsc_n) begin
        addr = WIN + AW'($urandom % 16);
        mode = 1'($urandom);
      end
      tick("R2");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule